// File: doc/BRIEF.md
# Round-Robin Multicycle Multiplier Array

This block multiplies a stream of unsigned operand pairs at one pair per clock, although no single multiplier has to finish within a clock. It holds `LANES` identical multiplier lanes. A rotating one-hot phase register gives each lane a load slot once every `LANES` cycles, so consecutive samples go to lanes 0, 1, …, `LANES`-1 and then back to lane 0. Each lane therefore has `LANES` full cycles to settle its product, which makes the lane multiplier a multicycle path.

A full-rate input register captures the operands and a valid flag. The lane in the current phase takes its operands from that register. On the same edge, a mux steered by the same phase bit passes that lane's settled product into the full-rate output register. The lane's old operands are replaced only after the product has been taken. Results leave in arrival order, with a fixed latency. A valid flag travels with every sample, so gaps in the input stream show up as gaps in the output.

Top module: `tiled_mul_array`

## Requirements
- R1: While `rst` is sampled high, and on every cycle after it until the first result is due, `out_valid` is 0. Reset also returns the phase rotation to lane 0.
- R2: Take a sample presented with `in_valid`=1 before rising edge E. Its result appears with `out_valid`=1 right after edge E+`LANES`+1.
- R3: Back-to-back valid samples produce back-to-back results in exactly the input order, one per cycle, with no stall.
- R4: `out_prod` is the full unsigned product of `in_a` and `in_b`, 2×`OP_W` bits wide, with no truncation. All-ones times all-ones gives (2^`OP_W`−1)².
- R5: A cycle with `in_valid`=0 produces a cycle with `out_valid`=0 at the same latency as R2. The pattern of gaps in the input is reproduced in the output.
- R6: Exactly one lane loads on every cycle. The loading lane advances by one each cycle and wraps from lane `LANES`-1 to lane 0.
- R7: A lane's operands stay unchanged for the `LANES` cycles between its loads, so its product has that many cycles to settle.
- R8: A reset asserted mid-stream discards every sample still in flight. None of them ever appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the operands on this cycle as a sample |
| in_a | input | OP_W | First unsigned operand |
| in_b | input | OP_W | Second unsigned operand |
| out_valid | output | 1 | Marks `out_prod` as a result |
| out_prod | output | 2*OP_W | Unsigned product |

## Verification
A fault in the phase rotation or in a lane's hold behaviour shows at the output within `LANES`+1 cycles: the result comes from the wrong lane, or from operands that changed too early. Either way a product no longer matches its sample, or results come out of order. A stuck or lost valid bit shows as a missing or extra `out_valid` at the slot where a result is due. The scoreboard checks every result against its expected product and against the exact edge it is due. It also checks every idle cycle for spurious output, so a timing slip of even one cycle is reported.

// File: rtl/tiled_mul_array.sv
module tiled_mul_array #(
  parameter int LANES = 5,
  parameter int OP_W  = 16,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_valid,
  output logic [PROD_W-1:0] out_prod
);

  if (LANES < 2) begin : g_bad_lanes
    $error("tiled_mul_array: LANES must be at least 2");
  end

  logic                        src_valid;
  logic [OP_W-1:0]             src_a, src_b;
  logic [LANES-1:0]            phase;
  logic [LANES-1:0]            lane_valid;
  logic [LANES-1:0][OP_W-1:0]  lane_a, lane_b;
  logic [LANES-1:0][PROD_W-1:0] lane_prod;
  logic                        sel_valid;
  logic [PROD_W-1:0]           sel_prod;

  always_ff @(posedge clk) begin
    if (rst) src_valid <= 1'b0;
    else     src_valid <= in_valid;
    src_a <= in_a;
    src_b <= in_b;
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= LANES'(1);
    else     phase <= {phase[LANES-2:0], phase[LANES-1]};
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (rst)
        lane_valid[k] <= 1'b0;
      else if (phase[k])
        lane_valid[k] <= src_valid;
      if (phase[k]) begin
        lane_a[k] <= src_a;
        lane_b[k] <= src_b;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_prod[k] = PROD_W'(lane_a[k]) * PROD_W'(lane_b[k]);
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_prod  = '0;
    for (int k = 0; k < LANES; k++) begin
      sel_valid = sel_valid | (phase[k] & lane_valid[k]);
      sel_prod  = sel_prod  | (lane_prod[k] & {PROD_W{phase[k]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= sel_valid;
    out_prod <= sel_prod;
  end

endmodule

module tiled_mul_array_chk #(
  parameter int LANES = 5,
  parameter int OP_W  = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [LANES-1:0]           phase,
  input logic [LANES-1:0]           lane_valid,
  input logic [LANES-1:0][OP_W-1:0] lane_a,
  input logic [LANES-1:0][OP_W-1:0] lane_b,
  input logic                       out_valid
);

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $countones(phase) == 1); // R6
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst) phase[LANES-1] |=> phase[0]); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid); // R1
  AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(|lane_valid)); // R5

  for (genvar k = 0; k < LANES; k++) begin : g_hold
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !phase[k] |=> ($stable(lane_a[k]) && $stable(lane_b[k]))); // R7
  end

endmodule

bind tiled_mul_array tiled_mul_array_chk #(.LANES(LANES), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .lane_valid(lane_valid),
  .lane_a(lane_a), .lane_b(lane_b), .out_valid(out_valid)
);

// File: tb/tiled_mul_array_test.sv
module tiled_mul_array_test;
  localparam int LANES  = 5;
  localparam int OP_W   = 16;
  localparam int PROD_W = 2 * OP_W;
  localparam int LAT    = LANES + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [OP_W-1:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic [PROD_W-1:0] out_prod;

  int checks = 0, errors = 0, edges = 0;
  bit started = 1'b0;
  string cur_req = "R1";
  logic [PROD_W-1:0] exp_q[$];
  int due_q[$];

  tiled_mul_array #(.LANES(LANES), .OP_W(OP_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  always #2 clk = ~clk;
  always @(posedge clk) begin
    edges <= edges + 1;
    started <= 1'b1;
  end

  task automatic send(input bit v, input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    @(negedge clk);
    in_valid = v;
    in_a = a;
    in_b = b;
    if (v) begin
      exp_q.push_back(PROD_W'(a) * PROD_W'(b));
      due_q.push_back(edges + 1 + LAT);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b0, '0, '0);
  endtask

  // Monitor: compares each output slot against the scoreboard (R2, R3, R4, R5).
  always @(negedge clk) begin
    if (started && !rst) begin
      checks++;
      if (due_q.size() > 0 && due_q[0] == edges) begin
        if (!out_valid || out_prod !== exp_q[0]) begin
          errors++;
          $display("FAIL %s edge %0d: valid=%0b prod=%0h expected valid=1 prod=%0h",
                   cur_req, edges, out_valid, out_prod, exp_q[0]);
        end
        void'(due_q.pop_front());
        void'(exp_q.pop_front());
      end else if (out_valid) begin
        errors++;
        $display("FAIL %s edge %0d: valid=1 prod=%0h expected valid=0", cur_req, edges, out_prod);
      end
    end
  end

  task automatic pulse_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    exp_q.delete();
    due_q.delete();
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state and quiet output afterwards
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid=%0b during reset expected 0", out_valid);
    end
    rst = 1'b0;
    idle(LAT + 3);

    // R2: single sample latency
    cur_req = "R2";
    send(1'b1, 16'd3, 16'd7);
    idle(LAT + 2);

    // R4: full-width unsigned corners
    cur_req = "R4";
    send(1'b1, 16'hFFFF, 16'hFFFF);
    send(1'b1, 16'hFFFF, 16'd1);
    send(1'b1, 16'd0, 16'hFFFF);
    send(1'b1, 16'h8000, 16'h8000);
    idle(LAT + 2);

    // R3, R6, R7: back-to-back stream across every lane
    cur_req = "R3";
    for (int i = 0; i < 40; i++) send(1'b1, OP_W'($urandom), OP_W'($urandom));
    idle(LAT + 2);

    // R5: gaps in the stream are reproduced
    cur_req = "R5";
    for (int i = 0; i < 30; i++) send((i % 3) != 1, OP_W'(i * 977 + 5), OP_W'(i * 31 + 2));
    idle(LAT + 2);

    // R8: in-flight samples discarded by a mid-stream reset
    cur_req = "R8";
    for (int i = 0; i < 6; i++) send(1'b1, OP_W'(i + 100), OP_W'(i + 200));
    pulse_reset(2);
    idle(LAT + 4);

    // R3: stream after reset, phase restarts at lane 0
    cur_req = "R3";
    for (int i = 0; i < 20; i++) send(1'b1, OP_W'($urandom), OP_W'($urandom));
    idle(LAT + 3);

    checks++;
    if (due_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results never appeared expected 0", due_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule